// File: doc/BRIEF.md
# SPI Byte-Addressed Serial Memory Slave

This block answers a host that talks to it over a four-wire serial link: chip select (active low), serial clock, serial data in, and serial data out with an output enable. The host sends one instruction byte, most significant bit first. Array commands then take an address byte and a run of data bytes. The block holds 512 bytes in an on-chip RAM, a write-enable latch, and a six-bit user status field. The host samples read data on the rising serial-clock edge, and the block moves SO after each falling edge.

The serial inputs pass through synchronisers into a fast system clock, which detects the clock edges. The serial clock may therefore stop at any level for any length of time, and the transfer picks up at the same bit. Write data goes into a 16-byte page buffer. The buffer is copied into the RAM only when chip select rises on a byte boundary, so an interrupted write leaves the array untouched. A read prefetches each byte from the synchronous RAM while the previous one is being shifted out.

Timing rule for the host: each serial-clock phase, and the gap between chip select falling and the first rising edge, lasts at least 6 system clocks. Leave 20 system clocks between chip select rising and the next fall, so that a pending page copy can finish.

Top module: `spi_ee_ctrl`

## Requirements
- R1: After reset, and whenever chip select is high, so_oe is 0. The status byte reads 0x00 after reset.
- R2: Instruction 0x06 sets the write-enable latch and 0x04 clears it. The status byte (instruction 0x05, then one or more dummy bytes) returns {user[5:0], latch, 0}, so the latch appears in bit 1.
- R3: Instruction 0000_A011 followed by address byte B starts a read at address {A, B}, where A is instruction bit 3. Each data byte is driven MSB first, and a new bit appears after every falling serial-clock edge.
- R4: During a read the 9-bit address increments after each byte and wraps from 511 to 0, for as long as chip select stays low.
- R5: Instruction 0000_A010, then an address byte, then 1 to 16 whole data bytes, with the latch set, stores those bytes at consecutive addresses once chip select rises.
- R6: While a write is in progress, only the low 4 address bits advance, and they wrap within the 16-byte page. A 17th byte overwrites the slot the first byte went to.
- R7: A write or status write issued while the latch is clear changes neither the array nor the status.
- R8: If chip select rises during a write data byte that is only partly received, the write is discarded completely, including the whole bytes before it.
- R9: The latch clears when chip select rises after a complete write (0000_A010) or status-write (0x01) instruction byte.
- R10: Instruction 0x01 followed by a whole data byte D, with the latch set, stores D[7:2] into status bits 7..2. Status bits 1 and 0 cannot be written.
- R11: so_oe is 1 only while read data or status bytes are being shifted out. It stays 0 during the instruction, address and write-data bytes.
- R12: If chip select rises before an instruction byte is complete, that instruction has no effect.
- R13: The serial clock may be held for any time in the middle of a byte, and the transfer continues correctly when clocking resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state is synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for so (1 = drive) |

## Verification
On every cycle the assertions check the following: the output enable drops behind chip select and appears only in the two read-out states; the read address moves only by +1 modulo 512; the latch clears after chip select ends a write-class command; and a page copy starts only when the latch was set and the last byte was whole. Whether the right bytes come back from the right addresses can only be shown by the bench's scenarios. The same holds for page wrap, the all-or-nothing abort of a partial write, status masking, and resumption after a clock pause. The bench checks these against a reference model of the array and the status.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [2:0] {
    ST_CMD   = 3'd0,
    ST_ADDR  = 3'd1,
    ST_WDATA = 3'd2,
    ST_RDATA = 3'd3,
    ST_SRD   = 3'd4,
    ST_SWR   = 3'd5,
    ST_SKIP  = 3'd6
  } ee_state_t;

  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [2:0] OP_ARR_RD    = 3'b011;
  localparam logic [2:0] OP_ARR_WR    = 3'b010;

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_act,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);

  logic [STAGES-1:0] cs_p, sck_p, si_p;
  logic              cs_d, sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p  <= '1;
      sck_p <= '0;
      si_p  <= '0;
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_p  <= {cs_p[STAGES-2:0], cs_n};
      sck_p <= {sck_p[STAGES-2:0], sck};
      si_p  <= {si_p[STAGES-2:0], si};
      cs_d  <= cs_p[STAGES-1];
      sck_d <= sck_p[STAGES-1];
    end
  end

  assign cs_act   = ~cs_p[STAGES-1];
  assign cs_rise  = cs_p[STAGES-1] & ~cs_d;
  assign sck_rise = sck_p[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_p[STAGES-1] & sck_d;
  assign si_s     = si_p[STAGES-1];

endmodule

// File: rtl/spi_ee_ram.sv
module spi_ee_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_ee_pagebuf.sv
module spi_ee_pagebuf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr,
  input  logic [PAGE_W-1:0] wslot,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PAGE_W-1:0] rslot,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              any
);

  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] buf_q [SLOTS];
  logic [SLOTS-1:0]  vld_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld_q <= '0;
    end else if (wr) begin
      vld_q[wslot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) buf_q[wslot] <= wdata;
  end

  assign rdata  = buf_q[rslot];
  assign rvalid = vld_q[rslot];
  assign any    = |vld_q;

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);

  localparam int DATA_W = 8;
  localparam int PG_HI  = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] LAST_SLOT = PAGE_W'((1 << PAGE_W) - 1);

  logic cs_act, cs_rise, sck_rise, sck_fall, si_s;

  spi_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_act(cs_act), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .si_s(si_s)
  );

  ee_state_t         state;
  logic [2:0]        bit_cnt;
  logic [DATA_W-1:0] shreg, so_sr;
  logic [ADDR_W-1:0] addr;
  logic              wel, wr_cmd, wr_ok, rd_sel, swr_have;
  logic [5:0]        user_q, swr_hi;
  logic              so_q, so_oe_q;

  logic              busy;
  logic [PAGE_W-1:0] cslot;
  logic [PG_HI-1:0]  cpage;

  logic [DATA_W-1:0] mem_rdata, pb_rdata, src;
  logic              pb_rvalid, pb_any;
  logic [DATA_W-1:0] inbyte;
  logic              byte_done, pb_wr, pb_clr, start_commit;

  assign inbyte    = {shreg[DATA_W-2:0], si_s};
  assign byte_done = cs_act && sck_rise && (bit_cnt == 3'd7);
  assign pb_wr     = byte_done && (state == ST_WDATA);
  assign pb_clr    = byte_done && (state == ST_ADDR) && !rd_sel;
  assign start_commit = cs_rise && (state == ST_WDATA) && wr_ok &&
                        (bit_cnt == 3'd0) && pb_any;
  assign src = (state == ST_RDATA) ? mem_rdata : {user_q, wel, 1'b0};

  spi_ee_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(busy && pb_rvalid), .waddr({cpage, cslot}),
    .wdata(pb_rdata), .raddr(addr), .rdata(mem_rdata)
  );

  spi_ee_pagebuf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_pbuf (
    .clk(clk), .rst(rst), .clr(pb_clr), .wr(pb_wr),
    .wslot(addr[PAGE_W-1:0]), .wdata(inbyte), .rslot(cslot),
    .rdata(pb_rdata), .rvalid(pb_rvalid), .any(pb_any)
  );

  // command sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_CMD;
      bit_cnt  <= '0;
      shreg    <= '0;
      so_sr    <= '0;
      addr     <= '0;
      wel      <= 1'b0;
      wr_cmd   <= 1'b0;
      wr_ok    <= 1'b0;
      rd_sel   <= 1'b0;
      swr_have <= 1'b0;
      swr_hi   <= '0;
      user_q   <= '0;
      so_q     <= 1'b0;
      so_oe_q  <= 1'b0;
    end else if (!cs_act) begin
      if (cs_rise) begin
        if (wr_cmd) wel <= 1'b0;
        if (state == ST_SWR && wr_ok && swr_have && bit_cnt == 3'd0)
          user_q <= swr_hi;
      end
      state    <= ST_CMD;
      bit_cnt  <= '0;
      wr_cmd   <= 1'b0;
      wr_ok    <= 1'b0;
      swr_have <= 1'b0;
      so_q     <= 1'b0;
      so_oe_q  <= 1'b0;
    end else begin
      if (sck_rise) begin
        shreg   <= inbyte;
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          unique case (state)
            ST_CMD: begin
              if (inbyte == OP_LATCH_SET) begin
                wel <= 1'b1; state <= ST_SKIP;
              end else if (inbyte == OP_LATCH_CLR) begin
                wel <= 1'b0; state <= ST_SKIP;
              end else if (inbyte == OP_STAT_RD) begin
                state <= ST_SRD;
              end else if (inbyte == OP_STAT_WR) begin
                state <= ST_SWR; wr_cmd <= 1'b1; wr_ok <= wel;
              end else if (inbyte[7:4] == 4'd0 && inbyte[2:0] == OP_ARR_RD) begin
                addr[ADDR_W-1] <= inbyte[3]; rd_sel <= 1'b1; state <= ST_ADDR;
              end else if (inbyte[7:4] == 4'd0 && inbyte[2:0] == OP_ARR_WR) begin
                addr[ADDR_W-1] <= inbyte[3]; rd_sel <= 1'b0; state <= ST_ADDR;
                wr_cmd <= 1'b1; wr_ok <= wel;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_ADDR: begin
              addr[ADDR_W-2:0] <= inbyte[ADDR_W-2:0];
              state <= rd_sel ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA: addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PAGE_W'(1);
            ST_SWR: begin
              swr_hi <= inbyte[7:2]; swr_have <= 1'b1;
            end
            default: ;
          endcase
        end
      end
      if (sck_fall && (state == ST_RDATA || state == ST_SRD)) begin
        so_oe_q <= 1'b1;
        if (bit_cnt == 3'd0) begin
          so_q  <= src[DATA_W-1];
          so_sr <= {src[DATA_W-2:0], 1'b0};
          if (state == ST_RDATA) addr <= addr + ADDR_W'(1);
        end else begin
          so_q  <= so_sr[DATA_W-1];
          so_sr <= {so_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  // page copy engine: walks every slot once after an accepted write
  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cslot <= '0;
      cpage <= '0;
    end else if (start_commit) begin
      busy  <= 1'b1;
      cslot <= '0;
      cpage <= addr[ADDR_W-1:PAGE_W];
    end else if (busy) begin
      cslot <= cslot + PAGE_W'(1);
      if (cslot == LAST_SLOT) busy <= 1'b0;
    end
  end

  assign so    = so_q;
  assign so_oe = so_oe_q;

endmodule

// File: rtl/spi_ee_chk.sv
module spi_ee_chk
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic              cs_rise,
  input ee_state_t         state,
  input logic [2:0]        bit_cnt,
  input logic              wel,
  input logic              wr_cmd,
  input logic              so_oe,
  input logic [ADDR_W-1:0] addr,
  input logic              busy
);

  a_r1_oe_off_when_deselected: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !so_oe);

  a_r11_oe_only_readout: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> (state == ST_RDATA || state == ST_SRD));

  a_r4_read_addr_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDATA && $past(state) == ST_RDATA && !$stable(addr))
      |-> addr == ADDR_W'($past(addr) + ADDR_W'(1)));

  a_r9_latch_drop: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && wr_cmd) |=> !wel);

  a_r7_copy_needs_latch: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel));

  a_r8_copy_whole_bytes: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bit_cnt) == 3'd0);

endmodule

bind spi_ee_ctrl spi_ee_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .cs_rise(cs_rise),
  .state(state), .bit_cnt(bit_cnt), .wel(wel), .wr_cmd(wr_cmd),
  .so_oe(so_oe), .addr(addr), .busy(busy)
);

// File: tb/sim_spi_ee_ctrl.sv
`timescale 1ns/1ps
module sim_spi_ee_ctrl;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;

  always #2 clk = ~clk;

  spi_ee_ctrl u0 (.clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
                  .so(so), .so_oe(so_oe));

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] exp_mem [512];
  logic       exp_wel;
  logic [5:0] exp_user;
  logic [7:0] wbuf [32];

  function automatic logic [7:0] exp_status();
    return {exp_user, exp_wel, 1'b0};
  endfunction

  function automatic logic [8:0] page_addr(logic [8:0] base, int k);
    return {base[8:4], 4'(base[3:0] + 4'(k))};
  endfunction

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int pause_at,
                      output logic [7:0] rx, output logic oe_all, output logic oe_any);
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = so; oe_all &= so_oe; oe_any |= so_oe;
      if (i == pause_at) begin
        repeat (400) @(negedge clk);
        n_tests++;
        if (so !== rx[i]) begin
          n_fail++;
          $display("FAIL R13 so moved during pause actual=%0b expected=%0b", so, rx[i]);
        end
      end
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic tx_quiet(input logic [7:0] tx, input string req);
    logic [7:0] rx; logic oa, on;
    xfer(tx, -1, rx, oa, on);
    check8(req, {7'd0, on}, 8'd0);
  endtask

  task automatic tx_bits(input logic [7:0] tx, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      si = tx[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    n_tests++;
    if (so_oe !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 so_oe with cs high actual=%0b expected=0", so_oe);
    end
    repeat (36) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel(); tx_quiet(op, "R11 instr"); desel();
    if (op == 8'h06) exp_wel = 1'b1;
    if (op == 8'h04) exp_wel = 1'b0;
  endtask

  task automatic read_status(input string req);
    logic [7:0] rx; logic oa, on;
    sel(); tx_quiet(8'h05, "R11 instr");
    for (int b = 0; b < 2; b++) begin
      xfer(8'h00, -1, rx, oa, on);
      check8(req, rx, exp_status());
      check8("R11 oe during status", {7'd0, oa}, 8'd1);
    end
    desel();
  endtask

  task automatic write_bytes(input logic [8:0] a, input int n);
    sel();
    tx_quiet({4'd0, a[8], 3'b010}, "R11 instr");
    tx_quiet(a[7:0], "R11 addr");
    for (int k = 0; k < n; k++) tx_quiet(wbuf[k], "R11 wdata");
    desel();
    if (exp_wel)
      for (int k = 0; k < n; k++) exp_mem[page_addr(a, k)] = wbuf[k];
    exp_wel = 1'b0;
  endtask

  task automatic read_check(input logic [8:0] a, input int n, input string req, input int pause_at);
    logic [7:0] rx; logic oa, on;
    sel();
    tx_quiet({4'd0, a[8], 3'b011}, "R11 instr");
    tx_quiet(a[7:0], "R11 addr");
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, (k == 0) ? pause_at : -1, rx, oa, on);
      check8(req, rx, exp_mem[9'(a + 9'(k))]);
      check8("R11 oe during read", {7'd0, oa}, 8'd1);
    end
    desel();
  endtask

  task automatic write_status(input logic [7:0] d);
    sel(); tx_quiet(8'h01, "R11 instr"); tx_quiet(d, "R11 sdata"); desel();
    if (exp_wel) exp_user = d[7:2];
    exp_wel = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
    exp_wel = 1'b0; exp_user = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check8("R1 so_oe after reset", {7'd0, so_oe}, 8'd0);
    read_status("R1 status after reset");

    cmd1(8'h06); read_status("R2 latch set");
    cmd1(8'h04); read_status("R2 latch clear");

    for (int k = 0; k < 4; k++) wbuf[k] = 8'hA0 + 8'(k);
    write_bytes(9'h020, 4);
    read_check(9'h020, 4, "R7 write without latch", -1);

    cmd1(8'h06);
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3; wbuf[2] = 8'h81;
    write_bytes(9'h1F0, 3);
    read_check(9'h1F0, 3, "R3 R5 high-half write/read", -1);
    read_status("R9 latch cleared after write");

    cmd1(8'h06);
    for (int k = 0; k < 17; k++) wbuf[k] = 8'h10 + 8'(k);
    write_bytes(9'h105, 17);
    read_check(9'h100, 16, "R6 page wrap", -1);

    cmd1(8'h06);
    sel();
    tx_quiet(8'h02, "R11 instr"); tx_quiet(8'h40, "R11 addr");
    tx_quiet(8'hEE, "R11 wdata"); tx_quiet(8'hDD, "R11 wdata");
    tx_bits(8'hFF, 5);
    desel();
    exp_wel = 1'b0;
    read_check(9'h040, 3, "R8 partial byte aborts", -1);
    read_status("R9 latch cleared after aborted write");

    cmd1(8'h06); wbuf[0] = 8'h77; wbuf[1] = 8'h88; write_bytes(9'h1FE, 2);
    cmd1(8'h06); wbuf[0] = 8'h99; wbuf[1] = 8'h66; write_bytes(9'h000, 2);
    read_check(9'h1FE, 4, "R4 read wrap 511->0", -1);

    write_status(8'hFF);
    read_status("R10 status write without latch");
    cmd1(8'h06); write_status(8'hAB);
    read_status("R10 status bits 7:2 stored");

    sel(); tx_bits(8'h06, 7); desel();
    read_status("R12 partial instruction ignored");

    read_check(9'h1F0, 2, "R13 clock pause mid-byte", 4);

    void'($urandom(32'd1234));
    for (int it = 0; it < 20; it++) begin
      automatic int op = int'($urandom_range(0, 3));
      automatic logic [8:0] a = 9'($urandom_range(0, 511));
      automatic int n = int'($urandom_range(1, 18));
      if (op == 0) cmd1(8'h06);
      else if (op == 1) begin
        if ($urandom_range(0, 3) != 0) cmd1(8'h06);
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        write_bytes(a, n);
      end else if (op == 2) read_check(a, n, "R3 R4 random read", -1);
      else read_status("R2 random status");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule